// File: doc/BRIEF.md
# Byte-Lane Static RAM Model

A clocked, synthesizable stand-in for a 16-bit asynchronous static RAM. It takes the usual active-low controls (chip select, write strobe, output enable and one enable per byte lane) and turns them into a decoded mode. The modes are deselect, write, read and outputs off. In place of a bidirectional pin it has a write-data bus, a read-data bus and one drive-enable bit per lane. A standby flag goes high when the part is deselected.

Each byte lane is decoded on its own. In one access a single lane can be written or read while the other lane stays undriven and keeps its stored value. Writes are taken on the rising clock edge while chip select and the write strobe are both low. Read data, drive enables and the standby flag are registered, so they follow the controls by one clock. The array depth comes from the address width. With an address width of 17 the array is 128K words of 16 bits. Reset clears the output registers and leaves the array alone.

Top module: `sram_lane_model`

## Requirements
- R1: While reset is held, and in the cycle after it is released, `rdrive` is 0, `rdata` is 0 and `standby` is 1.
- R2: If `ce_n` is 1 at a clock edge, then after that edge `standby` is 1 and `rdrive` is 0. No array word changes, whatever the other controls are.
- R3: A write takes place at an edge where `ce_n` and `we_n` are both 0. The value of `oe_n` has no effect on the write.
- R4: In a write, bits 7..0 of the addressed word take `wdata[7:0]` only if `lane_en_n[0]` is 0. Bits 15..8 take `wdata[15:8]` only if `lane_en_n[1]` is 0. A lane whose enable is 1 keeps its old value.
- R5: If `ce_n`=0, `we_n`=1 and `oe_n`=0 at an edge, then after that edge `rdrive[i]` equals the inverse of `lane_en_n[i]`. Each driven lane shows the stored byte of the addressed word.
- R6: If `ce_n`=0 and `we_n`=1 at an edge, and either `oe_n`=1 or both lane enables are 1, then after that edge `rdrive` is 0 and `standby` is 0.
- R7: After any write edge, `rdrive` is 0 on both lanes.
- R8: Whenever `rdrive[i]` is 0, the matching byte of `rdata` is all zeros.
- R9: Reset does not change array contents. A word written before a reset reads back unchanged after it.
- R10: If `ce_n` is 0 at an edge, `standby` is 0 after that edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset of the output registers |
| ce_n | input | 1 | Chip select, active low |
| we_n | input | 1 | Write strobe, active low |
| oe_n | input | 1 | Output enable, active low |
| lane_en_n | input | LANES (2) | Per-lane byte enable, active low; bit 0 is bits 7..0 |
| addr | input | ADDR_W | Word address |
| wdata | input | LANES*LANE_W (16) | Write data |
| rdata | output | LANES*LANE_W (16) | Registered read data, zero on undriven lanes |
| rdrive | output | LANES (2) | Registered per-lane drive enable |
| standby | output | 1 | Registered deselect flag |

## Verification
The bench builds the model with an address width of 6, so the array holds 64 words. Every word can then be filled by writes and read back within a short run. This covers both address extremes and every pairing of lane enables against written data. A reference model updated on each clock checks every output, every cycle. The run includes single-lane writes, a write with both lanes masked, deselected cycles with the write strobe low, and a reset in the middle of the run followed by a read-back.

// File: rtl/sram_lane_pkg.sv
// Shared types for the byte-lane static RAM model.
// Assumes nothing beyond the parameters passed to each module.
package sram_lane_pkg;
    typedef enum logic [1:0] {
        MODE_DESELECT = 2'd0,
        MODE_WRITE    = 2'd1,
        MODE_READ     = 2'd2,
        MODE_QUIET    = 2'd3
    } sram_mode_e;
endpackage

// File: rtl/sram_lane_decode.sv
// Control decoder: maps the active-low controls to a mode and to per-lane
// write and read strobes. Purely combinational; assumes inputs are stable
// around the sampling clock edge.
module sram_lane_decode
    import sram_lane_pkg::*;
#(
    parameter int LANES = 2
) (
    input  logic             ce_n,
    input  logic             we_n,
    input  logic             oe_n,
    input  logic [LANES-1:0] lane_en_n,
    output sram_mode_e       mode,
    output logic [LANES-1:0] lane_wr,
    output logic [LANES-1:0] lane_rd
);
    // Chip-level mode from the truth table; write ignores oe_n.
    always_comb begin
        if (ce_n)
            mode = MODE_DESELECT;
        else if (!we_n)
            mode = MODE_WRITE;
        else if (!oe_n && !(&lane_en_n))
            mode = MODE_READ;
        else
            mode = MODE_QUIET;
    end

    // Per-lane strobes: each lane qualified only by its own enable.
    for (genvar g = 0; g < LANES; g++) begin : g_lane
        assign lane_wr[g] = (mode == MODE_WRITE) && !lane_en_n[g];
        assign lane_rd[g] = (mode == MODE_READ)  && !lane_en_n[g];
    end
endmodule

// File: rtl/sram_lane_array.sv
// Storage: one bank per byte lane, each written independently on the
// clock edge. Combinational read of the addressed word. Contents are
// never reset.
module sram_lane_array #(
    parameter int LANES  = 2,
    parameter int LANE_W = 8,
    parameter int ADDR_W = 10,
    localparam int DEPTH  = 1 << ADDR_W,
    localparam int DATA_W = LANES * LANE_W
) (
    input  logic              clk,
    input  logic [ADDR_W-1:0] addr,
    input  logic [LANES-1:0]  lane_wr,
    input  logic [DATA_W-1:0] wdata,
    output logic [DATA_W-1:0] rword
);
    for (genvar g = 0; g < LANES; g++) begin : g_bank
        logic [LANE_W-1:0] bank [DEPTH];

        // Lane write: update this lane's byte when its strobe is set.
        always_ff @(posedge clk) begin
            if (lane_wr[g])
                bank[addr] <= wdata[g*LANE_W +: LANE_W];
        end

        assign rword[g*LANE_W +: LANE_W] = bank[addr];
    end
endmodule

// File: rtl/sram_lane_out.sv
// Output stage: registers the per-lane drive enables, the masked read
// data and the standby flag. Undriven lanes are forced to zero.
module sram_lane_out #(
    parameter int LANES  = 2,
    parameter int LANE_W = 8,
    localparam int DATA_W = LANES * LANE_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              deselect,
    input  logic [LANES-1:0]  lane_rd,
    input  logic [DATA_W-1:0] rword,
    output logic [DATA_W-1:0] rdata,
    output logic [LANES-1:0]  rdrive,
    output logic              standby
);
    // Standby flag register; set by reset.
    always_ff @(posedge clk) begin
        if (!rst_n)
            standby <= 1'b1;
        else
            standby <= deselect;
    end

    for (genvar g = 0; g < LANES; g++) begin : g_lane
        // Lane drive and data register; zero unless this lane is read.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                rdrive[g]                   <= 1'b0;
                rdata[g*LANE_W +: LANE_W]   <= '0;
            end else begin
                rdrive[g]                   <= lane_rd[g];
                rdata[g*LANE_W +: LANE_W]   <= lane_rd[g] ? rword[g*LANE_W +: LANE_W] : '0;
            end
        end
    end
endmodule

// File: rtl/sram_lane_model.sv
// Top: byte-lane static RAM model. Decoder, storage banks and output
// registers. Assumes synchronous use: controls sampled on rising clk.
module sram_lane_model
    import sram_lane_pkg::*;
#(
    parameter int LANES  = 2,
    parameter int LANE_W = 8,
    parameter int ADDR_W = 10,
    localparam int DATA_W = LANES * LANE_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ce_n,
    input  logic              we_n,
    input  logic              oe_n,
    input  logic [LANES-1:0]  lane_en_n,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] wdata,
    output logic [DATA_W-1:0] rdata,
    output logic [LANES-1:0]  rdrive,
    output logic              standby
);
    sram_mode_e        mode;
    logic [LANES-1:0]  lane_wr;
    logic [LANES-1:0]  lane_rd;
    logic [DATA_W-1:0] rword;

    sram_lane_decode #(.LANES(LANES)) u_decode (
        .ce_n      (ce_n),
        .we_n      (we_n),
        .oe_n      (oe_n),
        .lane_en_n (lane_en_n),
        .mode      (mode),
        .lane_wr   (lane_wr),
        .lane_rd   (lane_rd)
    );

    sram_lane_array #(.LANES(LANES), .LANE_W(LANE_W), .ADDR_W(ADDR_W)) u_array (
        .clk     (clk),
        .addr    (addr),
        .lane_wr (lane_wr),
        .wdata   (wdata),
        .rword   (rword)
    );

    sram_lane_out #(.LANES(LANES), .LANE_W(LANE_W)) u_out (
        .clk      (clk),
        .rst_n    (rst_n),
        .deselect (mode == MODE_DESELECT),
        .lane_rd  (lane_rd),
        .rword    (rword),
        .rdata    (rdata),
        .rdrive   (rdrive),
        .standby  (standby)
    );
endmodule

// File: rtl/sram_lane_model_chk.sv
// Checker for the byte-lane static RAM model: relates sampled controls
// to the registered outputs one clock later. Bound to the top below.
module sram_lane_model_chk #(
    parameter int LANES  = 2,
    parameter int LANE_W = 8
) (
    input logic                     clk,
    input logic                     rst_n,
    input logic                     ce_n,
    input logic                     we_n,
    input logic                     oe_n,
    input logic [LANES-1:0]         lane_en_n,
    input logic [LANES*LANE_W-1:0]  rdata,
    input logic [LANES-1:0]         rdrive,
    input logic                     standby
);
    // R2
    deselect_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ce_n |=> (standby && rdrive == '0));

    // R7
    write_undriven_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!ce_n && !we_n) |=> (rdrive == '0));

    // R5
    read_lanes_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!ce_n && we_n && !oe_n) |=> (rdrive == ~$past(lane_en_n)));

    // R6
    outputs_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!ce_n && we_n && (oe_n || (&lane_en_n))) |=> (rdrive == '0 && !standby));

    // R10
    active_no_standby_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !ce_n |=> !standby);

    for (genvar g = 0; g < LANES; g++) begin : g_lane
        // R8
        idle_lane_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
            !rdrive[g] |-> (rdata[g*LANE_W +: LANE_W] == '0));
    end
endmodule

bind sram_lane_model sram_lane_model_chk #(.LANES(LANES), .LANE_W(LANE_W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .ce_n      (ce_n),
    .we_n      (we_n),
    .oe_n      (oe_n),
    .lane_en_n (lane_en_n),
    .rdata     (rdata),
    .rdrive    (rdrive),
    .standby   (standby)
);

// File: tb/sram_lane_model_test.sv
// Bench for the byte-lane static RAM model. Inputs change on the falling
// edge; a behavioural reference updates on each rising edge and all
// outputs are compared on the following falling edge.
module sram_lane_model_test;
    localparam int AW    = 6;
    localparam int WORDS = 1 << AW;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          ce_n = 1'b1, we_n = 1'b1, oe_n = 1'b1;
    logic [1:0]    lane_en_n = 2'b11;
    logic [AW-1:0] addr = '0;
    logic [15:0]   wdata = '0;
    logic [15:0]   rdata;
    logic [1:0]    rdrive;
    logic          standby;

    int tests = 0;
    int fails = 0;
    bit done  = 0;
    int ref_mem [WORDS];

    always #5 clk = ~clk;

    sram_lane_model #(.LANES(2), .LANE_W(8), .ADDR_W(AW)) uut (
        .clk(clk), .rst_n(rst_n), .ce_n(ce_n), .we_n(we_n), .oe_n(oe_n),
        .lane_en_n(lane_en_n), .addr(addr), .wdata(wdata),
        .rdata(rdata), .rdrive(rdrive), .standby(standby)
    );

    task automatic check(string req, logic [15:0] ed, logic [1:0] er, logic es);
        tests++;
        if (rdata !== ed || rdrive !== er || standby !== es) begin
            fails++;
            $display("FAIL %s: got data=%h drive=%b sb=%b, expected data=%h drive=%b sb=%b",
                     req, rdata, rdrive, standby, ed, er, es);
        end
    endtask

    // One clock: drive at falling edge, model the edge, compare after it.
    task automatic cycle(string req, logic c, logic w, logic o, logic [1:0] en,
                         int a, logic [15:0] d);
        logic [15:0] ed;
        logic [1:0]  er;
        logic        es;
        ce_n = c; we_n = w; oe_n = o; lane_en_n = en; addr = AW'(a); wdata = d;
        ed = 16'h0; er = 2'b00; es = c;
        if (!c && !w) begin
            if (!en[0]) ref_mem[a][7:0]  = d[7:0];
            if (!en[1]) ref_mem[a][15:8] = d[15:8];
        end else if (!c && !o) begin
            er = ~en;
            if (!en[0]) ed[7:0]  = ref_mem[a][7:0];
            if (!en[1]) ed[15:8] = ref_mem[a][15:8];
        end
        @(posedge clk);
        @(negedge clk);
        check(req, ed, er, es);
    endtask

    task automatic do_reset(string req);
        ce_n = 1'b1; we_n = 1'b1; oe_n = 1'b1; lane_en_n = 2'b11;
        rst_n = 1'b0;
        @(posedge clk); @(negedge clk);
        check(req, 16'h0, 2'b00, 1'b1);
        @(posedge clk); @(negedge clk);
        check(req, 16'h0, 2'b00, 1'b1);
        rst_n = 1'b1;
    endtask

    initial begin
        @(negedge clk);
        do_reset("R1");
        // Fill the array; odd addresses write with oe_n low (R3, R7).
        for (int a = 0; a < WORDS; a++)
            cycle("R3", 1'b0, 1'b0, a[0] ? 1'b0 : 1'b1, 2'b00, a, 16'(a * 16'h0911 + 16'h3c5a));
        // Read back all words with rotating lane patterns (R5, R8, R10).
        for (int a = 0; a < WORDS; a++)
            cycle("R5", 1'b0, 1'b1, 1'b0, 2'(a % 3), a, 16'h0);
        // Single-lane and fully masked writes (R4).
        cycle("R4", 1'b0, 1'b0, 1'b1, 2'b10, 5, 16'hAAAA);
        cycle("R4", 1'b0, 1'b0, 1'b1, 2'b01, 9, 16'h5555);
        cycle("R4", 1'b0, 1'b0, 1'b0, 2'b11, 12, 16'hFFFF);
        cycle("R4", 1'b0, 1'b1, 1'b0, 2'b00, 5, 16'h0);
        cycle("R4", 1'b0, 1'b1, 1'b0, 2'b00, 9, 16'h0);
        cycle("R4", 1'b0, 1'b1, 1'b0, 2'b00, 12, 16'h0);
        // Deselected with write strobe low: nothing written (R2).
        cycle("R2", 1'b1, 1'b0, 1'b0, 2'b00, 3, 16'hDEAD);
        cycle("R2", 1'b1, 1'b1, 1'b0, 2'b00, 3, 16'h0);
        cycle("R2", 1'b0, 1'b1, 1'b0, 2'b00, 3, 16'h0);
        // Outputs off: oe_n high, or both lanes masked (R6).
        cycle("R6", 1'b0, 1'b1, 1'b1, 2'b00, 7, 16'h0);
        cycle("R6", 1'b0, 1'b1, 1'b0, 2'b11, 7, 16'h0);
        // Top and bottom addresses, single lane each (R5, R8).
        cycle("R5", 1'b0, 1'b1, 1'b0, 2'b10, WORDS - 1, 16'h0);
        cycle("R8", 1'b0, 1'b1, 1'b0, 2'b01, 0, 16'h0);
        // Reset mid-run; contents survive (R9).
        do_reset("R1");
        cycle("R9", 1'b0, 1'b1, 1'b0, 2'b00, 5, 16'h0);
        cycle("R9", 1'b0, 1'b1, 1'b0, 2'b00, 9, 16'h0);
        // Mixed stimulus from a simple generator (R2..R8, R10).
        begin
            int s = 32'h1234_5678;
            for (int i = 0; i < 400; i++) begin
                s = s * 1103515245 + 12345;
                cycle("R10", s[20] & s[21], s[22], s[23], s[25:24],
                      int'(s[14:9]), s[31:16]);
            end
        end
        done = 1;
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    // Watchdog: a hung run counts as a failed check.
    initial begin
        #(200000 * 10);
        if (!done) begin
            tests++;
            fails++;
            $display("FAIL watchdog: got running, expected finished");
            $display("[TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end
endmodule